// File: doc/BRIEF.md
# Pulse Generator Register Interface

This block is the 16-bit register-based slave that sits between a host bus and the timing core of a programmable pulse generator. It decodes aligned byte offsets into a small map. The map has two fixed identification words, a status/control word, four timing and mode registers that can be read back, and two write-only 12-bit reference-level codes for the output level converters. The block stores each configuration field and drives it to the core as a separate port. The relay-enable bit is brought out as a plain output.

A host raises `req_i` with `wr_i`, `addr_i` and `wdata_i` for one access. The block answers with a one-cycle `ack_o` in the next cycle, and read data is valid in that same cycle. The access control is a three-state machine:

- S_IDLE accepts a request. It goes to S_SRST for a write of 1 to bit 0 of offset 04h, and to S_RESP for any other request.
- S_RESP acknowledges and returns to S_IDLE.
- S_SRST acknowledges, pulses `soft_rst_o` and returns to S_IDLE. On that return, every timing and mode field is cleared.

Top module: `pg_regif`

## Requirements
- R1: After hardware reset, every configuration output, `rdata_o`, `ack_o` and `soft_rst_o` is zero.
- R2: A request seen in S_IDLE is acknowledged by `ack_o` high for exactly the next cycle. A request still held during that acknowledge cycle is ignored: it is not acknowledged and it does not write.
- R3: Offset 00h reads the identification word (parameter `ID_WORD`) and offset 02h reads FFFDh. Writes to either offset change nothing.
- R4: A read of offset 04h returns `modid_i` in bit 14, a Passed bit (1) in bit 3 and a Ready bit (1 once out of reset) in bit 2. Every other bit reads 0.
- R5: A write to 04h with bit 0 set raises `soft_rst_o` for exactly the acknowledge cycle. At the end of that cycle, the PRI, delay, width and mode registers (run and relay enable included) become zero. A write to 04h with bit 0 clear has no effect.
- R6: The PRI register at 08h holds relay enable in bit 15, a range in bits 14:12 and a multiplier in bits 9:0. It reads back as written ANDed with F3FFh.
- R7: The delay register at 0Ah holds a multiplier in bits 9:0. It reads back ANDed with 03FFh.
- R8: The pulse-width register at 0Ch holds a range in bits 14:12 and a multiplier in bits 9:0. It reads back ANDed with 73FFh.
- R9: The mode register at 0Eh holds run (bit 0), gated trigger (bit 1), delayed pulse (bit 2), free run (bit 3), double pulse (bit 4) and waveform select (bits 9:8). It reads back ANDed with 031Fh.
- R10: Writes to 10h and 12h load `wdata_i[11:0]` into the low and high reference codes. Both offsets read as zero. A soft reset leaves both codes unchanged.
- R11: An odd address, and any offset not listed above, reads zero and ignores writes. Such an access is still acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (6) | Byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid with ack |
| ack_o | output | 1 | One-cycle acknowledge |
| modid_i | input | 1 | Module-identify line reported in status |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| relay_en_o | output | 1 | Output relay enable |
| pri_range_o | output | 3 | Repetition interval range |
| pri_mult_o | output | 10 | Repetition interval multiplier |
| dly_mult_o | output | 10 | Delay multiplier |
| pw_range_o | output | 3 | Pulse width range |
| pw_mult_o | output | 10 | Pulse width multiplier |
| run_o | output | 1 | Run enable |
| trig_gated_o | output | 1 | 1 = gated trigger, 0 = edge trigger |
| dly_mode_o | output | 1 | Delayed pulse select |
| free_run_o | output | 1 | Free-running select |
| dbl_pulse_o | output | 1 | Double pulse select |
| wave_mode_o | output | 2 | Waveform select |
| ref_lo_o | output | 12 | Low reference code |
| ref_hi_o | output | 12 | High reference code |

## Verification
The bench holds a behavioural model of every field and compares all configuration outputs, `ack_o`, `soft_rst_o` and `rdata_o` against it on every clock. A wrong stored bit therefore appears on a core-facing port one cycle after the write edge. A wrong readback mask appears in the acknowledge cycle of the next read. A state machine stuck in S_RESP or S_SRST shows as `ack_o` or `soft_rst_o` lasting a second cycle, or as a held request being wrongly accepted. A bad clear shows as nonzero timing fields in the cycle after the pulse.

// File: rtl/pg_regs_pkg.sv
`timescale 1ns/1ps
package pg_regs_pkg;
    localparam int DW       = 16;
    localparam int MULT_W   = 10;
    localparam int RANGE_W  = 3;
    localparam int RANGE_LO = 12;
    localparam int RELAY_B  = 15;
    localparam int REF_W    = 12;
    localparam int WAVE_W   = 2;
    localparam int WAVE_LO  = 8;

    // mode register bit positions
    localparam int CTL_RUN  = 0;
    localparam int CTL_GATE = 1;
    localparam int CTL_DLY  = 2;
    localparam int CTL_FREE = 3;
    localparam int CTL_DBL  = 4;

    // status bit positions
    localparam int ST_READY = 2;
    localparam int ST_PASS  = 3;
    localparam int ST_MODID = 14;

    // byte offsets
    localparam int OFF_ID   = 'h00;
    localparam int OFF_DEV  = 'h02;
    localparam int OFF_STAT = 'h04;
    localparam int OFF_PRI  = 'h08;
    localparam int OFF_DLY  = 'h0A;
    localparam int OFF_PW   = 'h0C;
    localparam int OFF_CTL  = 'h0E;
    localparam int OFF_RLO  = 'h10;
    localparam int OFF_RHI  = 'h12;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RESP = 2'd1,
        S_SRST = 2'd2
    } bus_st_t;

    typedef struct packed {
        logic               relay;
        logic [RANGE_W-1:0] rng;
        logic [MULT_W-1:0]  mul;
    } pri_t;

    typedef struct packed {
        logic [RANGE_W-1:0] rng;
        logic [MULT_W-1:0]  mul;
    } pw_t;

    typedef struct packed {
        logic [WAVE_W-1:0] wave;
        logic              dbl;
        logic              free_run;
        logic              delayed;
        logic              gated;
        logic              run;
    } ctl_t;

    typedef struct packed {
        pri_t              pri;
        logic [MULT_W-1:0] dly;
        pw_t               pw;
        ctl_t              ctl;
    } timing_t;
endpackage

// File: rtl/pg_bus_fsm.sv
`timescale 1ns/1ps
module pg_bus_fsm
    import pg_regs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic          srst_bit_i,
    output logic          wr_stb_o,
    output logic          rd_stb_o,
    output logic          ack_o,
    output logic          srst_o,
    output logic          ready_o
);
    bus_st_t state_q, state_d;
    logic    ready_q;
    logic    srst_req;

    assign srst_req = wr_i && srst_bit_i && (addr_i == AW'(OFF_STAT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ready_q <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_i) state_d = srst_req ? S_SRST : S_RESP;
            S_RESP: state_d = S_IDLE;
            S_SRST: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        wr_stb_o = 1'b0;
        rd_stb_o = 1'b0;
        ack_o    = 1'b0;
        srst_o   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                wr_stb_o = req_i && wr_i;
                rd_stb_o = req_i && !wr_i;
            end
            S_RESP: ack_o = 1'b1;
            S_SRST: begin
                ack_o  = 1'b1;
                srst_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign ready_o = ready_q;

    // R2: an accepted request is answered in the next cycle
    p_req_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req_i) |=> ack_o);
    // R2: acknowledge lasts one cycle
    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
    // R5: soft reset is a single-cycle pulse
    p_srst_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |=> !srst_o);
endmodule

// File: rtl/pg_reg_bank.sv
`timescale 1ns/1ps
module pg_reg_bank
    import pg_regs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb_i,
    input  logic             srst_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    output timing_t          cfg_o,
    output logic [REF_W-1:0] ref_lo_o,
    output logic [REF_W-1:0] ref_hi_o
);
    timing_t          cfg_q;
    logic [REF_W-1:0] ref_lo_q, ref_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            ref_lo_q <= '0;
            ref_hi_q <= '0;
        end else if (srst_i) begin
            cfg_q <= '0;
        end else if (wr_stb_i && !addr_i[0]) begin
            case (addr_i)
                AW'(OFF_PRI): begin
                    cfg_q.pri.relay <= wdata_i[RELAY_B];
                    cfg_q.pri.rng   <= wdata_i[RANGE_LO +: RANGE_W];
                    cfg_q.pri.mul   <= wdata_i[MULT_W-1:0];
                end
                AW'(OFF_DLY): cfg_q.dly <= wdata_i[MULT_W-1:0];
                AW'(OFF_PW): begin
                    cfg_q.pw.rng <= wdata_i[RANGE_LO +: RANGE_W];
                    cfg_q.pw.mul <= wdata_i[MULT_W-1:0];
                end
                AW'(OFF_CTL): begin
                    cfg_q.ctl.run      <= wdata_i[CTL_RUN];
                    cfg_q.ctl.gated    <= wdata_i[CTL_GATE];
                    cfg_q.ctl.delayed  <= wdata_i[CTL_DLY];
                    cfg_q.ctl.free_run <= wdata_i[CTL_FREE];
                    cfg_q.ctl.dbl      <= wdata_i[CTL_DBL];
                    cfg_q.ctl.wave     <= wdata_i[WAVE_LO +: WAVE_W];
                end
                AW'(OFF_RLO): ref_lo_q <= wdata_i[REF_W-1:0];
                AW'(OFF_RHI): ref_hi_q <= wdata_i[REF_W-1:0];
                default: ;
            endcase
        end
    end

    assign cfg_o    = cfg_q;
    assign ref_lo_o = ref_lo_q;
    assign ref_hi_o = ref_hi_q;

    // R5: the pulse clears every timing and mode field
    p_srst_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (cfg_q == '0));
    // R10: reference codes survive the soft reset
    p_ref_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> ($stable(ref_lo_q) && $stable(ref_hi_q)));
endmodule

// File: rtl/pg_rd_mux.sv
`timescale 1ns/1ps
module pg_rd_mux
    import pg_regs_pkg::*;
#(
    parameter int          AW       = 6,
    parameter logic [15:0] ID_WORD  = 16'h0F3C,
    parameter logic [15:0] DEV_WORD = 16'hFFFD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stb_i,
    input  logic          wr_stb_i,
    input  logic [AW-1:0] addr_i,
    input  timing_t       cfg_i,
    input  logic          modid_i,
    input  logic          ready_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] sel_w, rdata_q;

    always_comb begin
        sel_w = '0;
        if (!addr_i[0]) begin
            case (addr_i)
                AW'(OFF_ID):  sel_w = ID_WORD;
                AW'(OFF_DEV): sel_w = DEV_WORD;
                AW'(OFF_STAT): begin
                    sel_w[ST_MODID] = modid_i;
                    sel_w[ST_PASS]  = 1'b1;
                    sel_w[ST_READY] = ready_i;
                end
                AW'(OFF_PRI): begin
                    sel_w[RELAY_B]               = cfg_i.pri.relay;
                    sel_w[RANGE_LO +: RANGE_W]   = cfg_i.pri.rng;
                    sel_w[MULT_W-1:0]            = cfg_i.pri.mul;
                end
                AW'(OFF_DLY): sel_w[MULT_W-1:0] = cfg_i.dly;
                AW'(OFF_PW): begin
                    sel_w[RANGE_LO +: RANGE_W] = cfg_i.pw.rng;
                    sel_w[MULT_W-1:0]          = cfg_i.pw.mul;
                end
                AW'(OFF_CTL): begin
                    sel_w[CTL_RUN]             = cfg_i.ctl.run;
                    sel_w[CTL_GATE]            = cfg_i.ctl.gated;
                    sel_w[CTL_DLY]             = cfg_i.ctl.delayed;
                    sel_w[CTL_FREE]            = cfg_i.ctl.free_run;
                    sel_w[CTL_DBL]             = cfg_i.ctl.dbl;
                    sel_w[WAVE_LO +: WAVE_W]   = cfg_i.ctl.wave;
                end
                default: sel_w = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_stb_i ? sel_w : '0;
    end

    assign rdata_o = rdata_q;

    // R11: a write returns no data
    p_wr_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_i |=> (rdata_q == '0));
endmodule

// File: rtl/pg_regif.sv
`timescale 1ns/1ps
module pg_regif
    import pg_regs_pkg::*;
#(
    parameter int          AW       = 6,
    parameter logic [15:0] ID_WORD  = 16'h0F3C,
    parameter logic [15:0] DEV_WORD = 16'hFFFD
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic                wr_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [15:0]         wdata_i,
    output logic [15:0]         rdata_o,
    output logic                ack_o,
    input  logic                modid_i,
    output logic                soft_rst_o,
    output logic                relay_en_o,
    output logic [RANGE_W-1:0]  pri_range_o,
    output logic [MULT_W-1:0]   pri_mult_o,
    output logic [MULT_W-1:0]   dly_mult_o,
    output logic [RANGE_W-1:0]  pw_range_o,
    output logic [MULT_W-1:0]   pw_mult_o,
    output logic                run_o,
    output logic                trig_gated_o,
    output logic                dly_mode_o,
    output logic                free_run_o,
    output logic                dbl_pulse_o,
    output logic [WAVE_W-1:0]   wave_mode_o,
    output logic [REF_W-1:0]    ref_lo_o,
    output logic [REF_W-1:0]    ref_hi_o
);
    logic    wr_stb, rd_stb, srst, ready;
    timing_t cfg;

    pg_bus_fsm #(.AW(AW)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .wr_i       (wr_i),
        .addr_i     (addr_i),
        .srst_bit_i (wdata_i[0]),
        .wr_stb_o   (wr_stb),
        .rd_stb_o   (rd_stb),
        .ack_o      (ack_o),
        .srst_o     (srst),
        .ready_o    (ready)
    );

    pg_reg_bank #(.AW(AW)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb_i (wr_stb),
        .srst_i   (srst),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .cfg_o    (cfg),
        .ref_lo_o (ref_lo_o),
        .ref_hi_o (ref_hi_o)
    );

    pg_rd_mux #(.AW(AW), .ID_WORD(ID_WORD), .DEV_WORD(DEV_WORD)) i_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb_i (rd_stb),
        .wr_stb_i (wr_stb),
        .addr_i   (addr_i),
        .cfg_i    (cfg),
        .modid_i  (modid_i),
        .ready_i  (ready),
        .rdata_o  (rdata_o)
    );

    assign soft_rst_o   = srst;
    assign relay_en_o   = cfg.pri.relay;
    assign pri_range_o  = cfg.pri.rng;
    assign pri_mult_o   = cfg.pri.mul;
    assign dly_mult_o   = cfg.dly;
    assign pw_range_o   = cfg.pw.rng;
    assign pw_mult_o    = cfg.pw.mul;
    assign run_o        = cfg.ctl.run;
    assign trig_gated_o = cfg.ctl.gated;
    assign dly_mode_o   = cfg.ctl.delayed;
    assign free_run_o   = cfg.ctl.free_run;
    assign dbl_pulse_o  = cfg.ctl.dbl;
    assign wave_mode_o  = cfg.ctl.wave;
endmodule

// File: tb/test_pg_regif.sv
`timescale 1ns/1ps
module test_pg_regif;
    localparam logic [15:0] IDW = 16'h0F3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0, modid = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ack, srst, relay, run, gated, dmode, free, dbl;
    logic [2:0]  pri_rng, pw_rng;
    logic [9:0]  pri_mul, dly_mul, pw_mul;
    logic [1:0]  wave;
    logic [11:0] rlo, rhi;

    always #4 clk = ~clk;

    pg_regif #(.AW(6), .ID_WORD(IDW), .DEV_WORD(16'hFFFD)) i_pg_regif (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack), .modid_i(modid),
        .soft_rst_o(srst), .relay_en_o(relay), .pri_range_o(pri_rng),
        .pri_mult_o(pri_mul), .dly_mult_o(dly_mul), .pw_range_o(pw_rng),
        .pw_mult_o(pw_mul), .run_o(run), .trig_gated_o(gated),
        .dly_mode_o(dmode), .free_run_o(free), .dbl_pulse_o(dbl),
        .wave_mode_o(wave), .ref_lo_o(rlo), .ref_hi_o(rhi)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [15:0] m_pri = 0, m_dly = 0, m_pw = 0, m_ctl = 0;
    logic [11:0] m_rlo = 0, m_rhi = 0;
    logic        e_ack = 0, e_srst = 0;
    logic [15:0] e_rdata = 0;
    logic [15:0] last_rd;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] m_read(logic [5:0] a);
        if (a[0]) return 16'h0;
        case (a)
            6'h00: return IDW;
            6'h02: return 16'hFFFD;
            6'h04: return {1'b0, modid, 10'b0, 1'b1, 1'b1, 2'b00};
            6'h08: return m_pri;
            6'h0A: return m_dly;
            6'h0C: return m_pw;
            6'h0E: return m_ctl;
            default: return 16'h0;
        endcase
    endfunction

    function automatic bit m_write(logic [5:0] a, logic [15:0] d);
        if (a[0]) return 0;
        case (a)
            6'h04: return d[0];
            6'h08: m_pri = d & 16'hF3FF;
            6'h0A: m_dly = d & 16'h03FF;
            6'h0C: m_pw  = d & 16'h73FF;
            6'h0E: m_ctl = d & 16'h031F;
            6'h10: m_rlo = d[11:0];
            6'h12: m_rhi = d[11:0];
            default: ;
        endcase
        return 0;
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) if (rst_n && !done) begin
        chk("R6 PRI fields",   {16'h0, relay, pri_rng, 2'b00, pri_mul}, {16'h0, m_pri});
        chk("R7 delay field",  {16'h0, 6'b0, dly_mul}, {16'h0, m_dly});
        chk("R8 width fields", {16'h0, 1'b0, pw_rng, 2'b00, pw_mul}, {16'h0, m_pw});
        chk("R9 mode fields",  {16'h0, 6'b0, wave, 3'b0, dbl, free, dmode, gated, run}, {16'h0, m_ctl});
        chk("R10 ref codes",   {8'h0, rlo, rhi}, {8'h0, m_rlo, m_rhi});
        chk("R2 ack",          {31'h0, ack}, {31'h0, e_ack});
        chk("R5 soft reset",   {31'h0, srst}, {31'h0, e_srst});
        chk("rdata R3/R4/R11", {16'h0, rdata}, {16'h0, e_rdata});
    end

    task automatic access(bit w, logic [5:0] a, logic [15:0] d, bit hold2 = 0);
        bit s = 0;
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        @(posedge clk); #1;
        if (w) s = m_write(a, d);
        else   e_rdata = m_read(a);
        e_ack = 1'b1; e_srst = s;
        if (hold2) begin
            @(negedge clk);
            last_rd = rdata;
            wdata = ~d;
            @(posedge clk); #1;
            e_ack = 1'b0; e_rdata = '0;
            @(negedge clk);
            req = 1'b0;
        end else begin
            @(negedge clk);
            last_rd = rdata;
            req = 1'b0;
            @(posedge clk); #1;
            e_ack = 1'b0; e_srst = 1'b0; e_rdata = '0;
            if (s) begin m_pri = 0; m_dly = 0; m_pw = 0; m_ctl = 0; end
        end
    endtask

    task automatic rd_chk(string tag, logic [5:0] a, logic [15:0] exp);
        access(0, a, 16'h0);
        chk(tag, {16'h0, last_rd}, {16'h0, exp});
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: everything clear after reset
        chk("R1 reset outputs", {relay, pri_rng, pri_mul, dly_mul, pw_rng, run, ack, srst},
            '0);
        chk("R1 reset refs/rdata", {4'h0, rlo, rdata}, '0);
        @(negedge clk);

        // R3 identification words and their write protection
        rd_chk("R3 id word", 6'h00, IDW);
        rd_chk("R3 device type", 6'h02, 16'hFFFD);
        access(1, 6'h00, 16'h1234);
        access(1, 6'h02, 16'h0000);
        rd_chk("R3 id after write", 6'h00, IDW);
        rd_chk("R3 device type after write", 6'h02, 16'hFFFD);

        // R4 status bits
        rd_chk("R4 status modid low", 6'h04, 16'h000C);
        modid = 1'b1;
        rd_chk("R4 status modid high", 6'h04, 16'h400C);
        modid = 1'b0;

        // R6..R9 readback masking
        access(1, 6'h08, 16'hFFFF);
        rd_chk("R6 PRI mask", 6'h08, 16'hF3FF);
        access(1, 6'h08, 16'h5A5A);
        rd_chk("R6 PRI pattern", 6'h08, 16'h525A);
        access(1, 6'h0A, 16'hFFFF);
        rd_chk("R7 delay mask", 6'h0A, 16'h03FF);
        access(1, 6'h0C, 16'hFFFF);
        rd_chk("R8 width mask", 6'h0C, 16'h73FF);
        access(1, 6'h0E, 16'hFFFF);
        rd_chk("R9 mode mask", 6'h0E, 16'h031F);

        // R10 write-only reference codes
        access(1, 6'h10, 16'hFABC);
        access(1, 6'h12, 16'h1357);
        chk("R10 low code", {20'h0, rlo}, 32'h0ABC);
        chk("R10 high code", {20'h0, rhi}, 32'h0357);
        rd_chk("R10 low reads zero", 6'h10, 16'h0);
        rd_chk("R10 high reads zero", 6'h12, 16'h0);

        // R11 unmapped and odd offsets
        access(1, 6'h06, 16'hFFFF);
        access(1, 6'h14, 16'hFFFF);
        access(1, 6'h09, 16'h0000);
        rd_chk("R11 unmapped 06h", 6'h06, 16'h0);
        rd_chk("R11 unmapped 3Eh", 6'h3E, 16'h0);
        rd_chk("R11 odd address", 6'h09, 16'h0);
        rd_chk("R11 PRI untouched by odd write", 6'h08, 16'h525A);

        // R2 request held through the acknowledge is not taken twice
        access(1, 6'h0A, 16'h0123, 1);
        rd_chk("R2 held request ignored", 6'h0A, 16'h0123);

        // R5 status write without bit 0 does nothing
        access(1, 6'h0E, 16'h0119);
        access(1, 6'h04, 16'hFFFE);
        rd_chk("R5 no reset on bit0 clear", 6'h0E, 16'h0119);
        // R5 soft reset clears timing, R10 keeps references
        access(1, 6'h04, 16'h0001);
        chk("R5 relay and run cleared", {30'h0, relay, run}, 32'h0);
        rd_chk("R5 PRI cleared", 6'h08, 16'h0);
        rd_chk("R5 mode cleared", 6'h0E, 16'h0);
        chk("R10 refs kept", {8'h0, rlo, rhi}, {8'h0, 12'hABC, 12'h357});

        // mixed patterns
        for (int i = 0; i < 24; i++) begin
            logic [5:0]  a;
            logic [15:0] d;
            case (i % 6)
                0: a = 6'h08; 1: a = 6'h0A; 2: a = 6'h0C;
                3: a = 6'h0E; 4: a = 6'h10; default: a = 6'h12;
            endcase
            d = 16'(i * 16'h3B1D) ^ 16'hA5C3;
            access(1, a, d);
            access(0, a, 16'h0);
        end

        finish_up();
    end
endmodule